// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the digital side of a single-channel 14-bit successive-approximation converter used with a chip-select style serial host over three wires, with no busy signal. It runs in a fast system clock domain. The CNV, SCK and SDI pins arrive asynchronously, so the block synchronises them and detects their edges. When CNV rises while SDI is high, the block starts a conversion of fixed length, counted in system clocks. That conversion always runs to its end. At the end the block captures the parallel result from a stubbed converter core and enters acquisition.

After the conversion, the host pulls CNV low. That fall acts as the chip select, and the block drives the most significant result bit at once. Each following SCK falling edge moves the output one bit lower. The output floats again after the last bit, or as soon as CNV goes back high, whichever comes first. The tri-state SDO pin is modelled as a data bit plus an output enable.

Top module: `sar_serial_port`

## Requirements
- R1: After reset the output enable is low and stays low until a readout begins.
- R2: A conversion lasts CONV_CYCLES clocks. A CNV fall presented CONV_CYCLES clocks or fewer after the CNV rise that started it produces no readout. A fall presented CONV_CYCLES+1 clocks or more after that rise starts the readout.
- R3: A CNV rise while SDI is low starts no conversion, and a later CNV fall then drives nothing. Each conversion result is read out at most once.
- R4: The result is captured from the core input in the last conversion clock. Later changes on the core input do not alter the bits read out.
- R5: A CNV fall in acquisition with an unread result raises the output enable and presents result bit 13 three clocks after the pin changes.
- R6: The n-th SCK falling edge of a readout presents result bit 13-n. After the 14th falling edge the output enable drops.
- R7: A CNV rise drops the output enable within three clocks, whatever the number of bits already sent. With SDI high it also starts a new conversion, and the next readout begins again at bit 13.
- R8: If CNV falls while a conversion is still running, the output enable stays low and no data is shifted out until the next conversion.
- R9: SCK edges while CNV is high or during a conversion have no effect on the bits of the next readout.
- R10: While the output enable is high, the data bit changes only after an SCK falling edge, so it holds across the SCK rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Conversion start and chip select pin, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Mode select pin, high for chip-select mode |
| core_result_i | input | 14 | Parallel result from the converter core |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for the serial data pin, low means high impedance |

## Verification
Full readouts are run with walking-one and walking-zero words, all-zeros, all-ones and both alternating words. These separate a wrong shift direction, a stuck or swapped bit, and an off-by-one in the bit count. Every readout is preceded by SCK toggling during the conversion and while CNV is high, and the core input is inverted after capture, so stray shifts or late sampling show up as wrong bits. A sweep stops the readout with a CNV rise after each possible number of bits and then reads the next conversion in full, which checks early release and the restart of the bit count. Two CNV falls placed one clock apart around the end of a conversion pin down its length exactly.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_e;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import sar_port_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_rise_i,
  input  logic              cnv_fall_i,
  input  logic              sdi_lvl_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] core_i,
  output phase_e            phase_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic              ready_q;
  logic [DATA_W-1:0] result_q;
  logic              start;

  assign start = cnv_rise_i && sdi_lvl_i && (phase_q != PH_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      ready_q  <= 1'b0;
      result_q <= '0;
    end else if (start) begin
      phase_q <= PH_CONV;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      ready_q <= 1'b0;
    end else if (phase_q == PH_CONV) begin
      if (cnv_fall_i) armed_q <= 1'b0;
      if (cnt_q == LAST) begin
        phase_q  <= PH_ACQ;
        result_q <= core_i;
        ready_q  <= armed_q && !cnv_fall_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (take_i) begin
      ready_q <= 1'b0;
    end
  end

  assign phase_o  = phase_q;
  assign ready_o  = ready_q;
  assign result_o = result_q;
endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              sck_fall_i,
  input  logic              release_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shreg_q;
  logic [LEFT_W-1:0] left_q;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      left_q  <= '0;
      oe_q    <= 1'b0;
    end else if (release_i) begin
      oe_q <= 1'b0;
    end else if (load_i) begin
      shreg_q <= data_i;
      left_q  <= LEFT_W'(DATA_W);
      oe_q    <= 1'b1;
    end else if (oe_q && sck_fall_i) begin
      if (left_q == LEFT_W'(1)) begin
        oe_q <= 1'b0;
      end else begin
        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        left_q  <= left_q - 1'b1;
      end
    end
  end

  assign sdo_o = shreg_q[DATA_W-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_port_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] core_result_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int PIN_CNV = 0;
  localparam int PIN_SCK = 1;
  localparam int PIN_SDI = 2;

  logic [2:0]        pin_lvl, pin_rise, pin_fall;
  logic              cnv_rise, cnv_fall, sck_fall;
  phase_e            phase;
  logic              ready;
  logic              load;
  logic [DATA_W-1:0] result;

  pin_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .pin_i   ({sdi_i, sck_i, cnv_i}),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  assign cnv_rise = pin_rise[PIN_CNV];
  assign cnv_fall = pin_fall[PIN_CNV];
  assign sck_fall = pin_fall[PIN_SCK];
  assign load     = cnv_fall && (phase == PH_ACQ) && ready;

  conv_sequencer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .cnv_rise_i (cnv_rise),
    .cnv_fall_i (cnv_fall),
    .sdi_lvl_i  (pin_lvl[PIN_SDI]),
    .take_i     (load),
    .core_i     (core_result_i),
    .phase_o    (phase),
    .ready_o    (ready),
    .result_o   (result)
  );

  bit_shifter #(.DATA_W(DATA_W)) shf_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .sck_fall_i (sck_fall),
    .release_i  (cnv_rise),
    .data_i     (result),
    .sdo_o      (sdo_o),
    .oe_o       (sdo_oe_o)
  );
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk
  import sar_port_pkg::*;
#(
  parameter int CONV_CYCLES = 24
) (
  input logic   clk,
  input logic   rst,
  input phase_e phase,
  input logic   cnv_rise,
  input logic   sck_fall,
  input logic   sdo_o,
  input logic   sdo_oe_o
);
  logic [31:0] conv_len_q;

  always_ff @(posedge clk) begin
    if (rst)                    conv_len_q <= '0;
    else if (phase == PH_CONV)  conv_len_q <= conv_len_q + 1;
    else                        conv_len_q <= '0;
  end

  // R2: a conversion never outlasts its length
  p_conv_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV) |-> (conv_len_q < 32'(CONV_CYCLES)));

  // R2: leaving conversion happens exactly at its length
  p_conv_exact_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_CONV && phase != PH_CONV) |-> (conv_len_q == 32'(CONV_CYCLES)));

  // R8: output is only driven during acquisition
  p_oe_in_acq_r8: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> (phase == PH_ACQ));

  // R7: a chip-select release floats the output
  p_rise_floats_r7: assert property (@(posedge clk) disable iff (rst)
    cnv_rise |=> !sdo_oe_o);

  // R10: data bit only moves after a serial clock fall
  p_sdo_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(sck_fall)) |-> $stable(sdo_o));
endmodule

bind sar_serial_port sar_serial_port_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .phase    (phase),
  .cnv_rise (cnv_rise),
  .sck_fall (sck_fall),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/sar_serial_port_tb_top.sv
module sar_serial_port_tb_top;
  localparam int DW = 14;
  localparam int CC = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnv = 1'b0;
  logic          sck = 1'b0;
  logic          sdi = 1'b1;
  logic [DW-1:0] core = '0;
  logic          sdo, oe;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  always #2 clk = ~clk;

  sar_serial_port #(.DATA_W(DW), .CONV_CYCLES(CC), .SYNC_STAGES(2)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .cnv_i         (cnv),
    .sck_i         (sck),
    .sdi_i         (sdi),
    .core_result_i (core),
    .sdo_o         (sdo),
    .sdo_oe_o      (oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sck_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; tick(2);
      sck = 1'b0; tick(2);
    end
  endtask

  // R9: serial clock toggled during conversion; R4: core changed after capture
  task automatic start_conv(input logic [DW-1:0] d);
    core = d;
    sdi  = 1'b1;
    cnv  = 1'b1;
    tick(2);
    sck_pulses(3);
    tick(CC - 4);
    sck_pulses(2);
    core = ~d;
  endtask

  task automatic read_frame(input logic [DW-1:0] d, input string req);
    logic [DW-1:0] got;
    bit            oe_ok, hold_ok, end_ok;
    got     = '0;
    oe_ok   = 1'b1;
    hold_ok = 1'b1;
    cnv = 1'b0;
    tick(4);
    oe_ok &= oe;
    got[DW-1] = sdo;
    for (int i = 1; i < DW; i++) begin
      sck = 1'b1; tick(4);
      oe_ok &= oe;
      if (sdo !== got[DW-i]) hold_ok = 1'b0;
      sck = 1'b0; tick(4);
      oe_ok &= oe;
      got[DW-1-i] = sdo;
    end
    sck = 1'b1; tick(4);
    sck = 1'b0; tick(4);
    end_ok = !oe;
    check(oe_ok && got == d, {req, " R6 R9 frame bits"}, int'(got), int'(d));
    check(hold_ok, "R10 bit held across SCK rise", 0, 1);
    check(end_ok, "R6 float after 14th fall", int'(oe), 0);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    check(oe == 1'b0, "R1 reset floats SDO", int'(oe), 0);
    tick(20);
    check(oe == 1'b0, "R1 idle floats SDO", int'(oe), 0);

    // Pattern sweep
    for (int p = 0; p < 32; p++) begin
      logic [DW-1:0] d;
      if (p < 14)       d = DW'(1) << p;
      else if (p < 28)  d = ~(DW'(1) << (p - 14));
      else if (p == 28) d = '0;
      else if (p == 29) d = '1;
      else if (p == 30) d = 14'h2AAA;
      else              d = 14'h1555;
      start_conv(d);
      read_frame(d, "R4");
      tick(3);
    end

    // R5 latency of the first bit, then R7 release and R3 no second readout
    start_conv(14'h2D31);
    cnv = 1'b0;
    tick(2);
    check(oe == 1'b0, "R5 no drive before three clocks", int'(oe), 0);
    tick(1);
    check(oe == 1'b1 && sdo == 1'b1, "R5 MSB on third clock", int'({oe, sdo}), 3);
    sdi = 1'b0;
    cnv = 1'b1;
    tick(3);
    check(oe == 1'b0, "R7 CNV rise floats SDO", int'(oe), 0);
    tick(CC + 8);
    cnv = 1'b0;
    tick(8);
    check(oe == 1'b0, "R3 SDI low starts nothing", int'(oe), 0);
    sdi = 1'b1;

    // R7 early release after k bits, then a full restart frame
    for (int k = 1; k < DW; k++) begin
      logic [DW-1:0] d;
      d = 14'h3FFF ^ DW'(k * 9);
      start_conv(d);
      cnv = 1'b0;
      tick(4);
      for (int j = 0; j < k; j++) begin
        sck = 1'b1; tick(4);
        sck = 1'b0; tick(4);
      end
      check(oe == 1'b1 && sdo == d[DW-1-k], "R6 bit after k falls", int'({oe, sdo}), int'({1'b1, d[DW-1-k]}));
      cnv = 1'b1;
      tick(3);
      check(oe == 1'b0, "R7 early release", int'(oe), 0);
      tick(CC + 8);
      read_frame(~d, "R7 restart");
      tick(3);
    end

    // R2 boundary: fall at CC+1 clocks reads, fall at CC clocks does not (R8)
    core = 14'h2222;
    cnv  = 1'b1;
    tick(CC + 1);
    cnv = 1'b0;
    tick(4);
    check(oe == 1'b1 && sdo == 1'b1, "R2 fall after end reads", int'({oe, sdo}), 3);
    cnv = 1'b1;
    tick(CC);
    cnv = 1'b0;
    tick(CC + 10);
    check(oe == 1'b0, "R8 fall during conversion", int'(oe), 0);
    sck_pulses(4);
    check(oe == 1'b0, "R8 no shifting after early fall", int'(oe), 0);
    start_conv(14'h2222);
    read_frame(14'h2222, "R2 after early fall");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule